// File: doc/BRIEF.md
# Write-Protect Command Sequencer

This block sits between a bus write-strobe detector and a sector program controller in a byte-wide flash interface. Every host write arrives as a one-cycle strobe with its address and data. The block looks for short command byte sequences in that stream. One sequence arms a sector write and, if protection is off, also turns protection on. A longer sequence turns protection off. Two other sequences enter and leave an identification mode. Any write that is not part of a sequence is passed to the program controller as an ordinary byte load.

The block keeps a protection flag that the normal reset does not clear. Only a separate factory clear input resets it. The block tells the program controller whether the current load window may change the array. When protection is on and no unlock has been seen, writes still load and still start the timed cycle downstream, but the write permission is low, so the array stays unchanged. A change to the protection flag takes effect only when the program controller signals the end of the cycle that carried the command.

In identification mode, reads are redirected to fixed codes chosen by the lowest read address bit. Outside that mode, reads return array data unchanged.

Top module: `wp_cmd_seq`

## Requirements
- R1: A write strobe that is not consumed by a command sequence pulses `byte_load` in the same cycle. The bytes of a recognised sequence, or of a sequence still in progress, never pulse it.
- R2: The unlock sequence is 0xAA at 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555. Issued while `prot_on` is 0, it leaves `prot_on` at 0 until the next `cyc_end`, after which `prot_on` reads 1.
- R3: While `prot_on` is 1, `write_ok` is 0 unless the unlock sequence has been given since the last `cyc_end`. After an unlock it reads 1 until the next `cyc_end`, after which it reads 0 again.
- R4: The disable sequence is six bytes: 0xAA at 0x5555, 0x55 at 0x2AAA, 0x80 at 0x5555, 0xAA at 0x5555, 0x55 at 0x2AAA, 0x20 at 0x5555. It raises `write_ok` at once. It clears `prot_on` only at the next `cyc_end`.
- R5: `prot_on` keeps its value through `rst_n` and changes only at `cyc_end` or at `factory_n` low, which clears it.
- R6: After 0xAA at 0x5555, 0x55 at 0x2AAA, 0x90 at 0x5555, `id_mode` is 1. In this mode `rd_data` is 0x1F when `rd_a0` is 0 and 0xDA when `rd_a0` is 1. The same prefix ending in 0xF0 at 0x5555 sets `id_mode` back to 0.
- R7: `rst_n` low clears `id_mode`, any partly matched sequence, and any unlock or pending protection change.
- R8: A byte that does not continue a partly matched sequence abandons the match. That byte pulses `byte_load`, and the earlier prefix bytes are dropped. The next 0xAA at 0x5555 starts a new match.
- R9: When `id_mode` is 0, `rd_data` equals `arr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; does not touch the protection flag |
| factory_n | input | 1 | Synchronous active-low factory clear of the protection flag |
| wr_stb | input | 1 | One-cycle pulse per host write |
| wr_addr | input | 15 | Low command-address bits of the write |
| wr_data | input | 8 | Write data byte |
| cyc_end | input | 1 | Pulse from the program controller at the end of a program cycle |
| rd_a0 | input | 1 | Lowest bit of the read address |
| arr_data | input | 8 | Byte read from the array |
| byte_load | output | 1 | The current write is an ordinary data byte |
| write_ok | output | 1 | The pending load window may change the array |
| prot_on | output | 1 | Persistent write-protection flag |
| id_mode | output | 1 | Identification mode active |
| rd_data | output | 8 | Read data returned to the host |

## Verification
A sequence state that is stuck or wrongly advanced shows up at once on `byte_load`, in the same cycle as the next write. Command bytes then leak out as data loads, or data bytes are swallowed. A wrong unlock or pending bit shows on `write_ok` one cycle after the final command byte. A wrong protection flag stays hidden until the next `cyc_end` and then shows on `prot_on` the cycle after. The checks therefore look at each of these points, before and after the cycle end as well as across a reset.

// File: rtl/wp_cmd_pkg.sv
// Package: shared types for the write-protect command sequencer.
// Assumes a byte-wide data path and single-cycle write strobes.
package wp_cmd_pkg;

    // Progress through a command byte sequence
    typedef enum logic [2:0] {
        SQ_IDLE,   // nothing matched
        SQ_P1,     // lead byte seen
        SQ_P2,     // lead and second byte seen
        SQ_D3,     // extended prefix byte seen (disable path)
        SQ_D4,     // extended lead byte seen
        SQ_D5      // extended second byte seen
    } seq_t;

    // One-cycle pulses when a sequence completes
    typedef struct packed {
        logic arm;     // unlock / enable sequence
        logic unprot;  // disable sequence
        logic id_in;   // identification entry
        logic id_out;  // identification exit
    } cmd_hits_t;

endpackage

// File: rtl/wp_cmd_match.sv
// Module: command byte sequence matcher.
// Follows write strobes through the three-byte and six-byte command
// sequences. Reports completed commands as one-cycle pulses and marks
// each write as either consumed by a sequence or an ordinary data load.
// Assumes wr_stb is high for exactly one cycle per host write.
module wp_cmd_match
    import wp_cmd_pkg::*;
#(
    parameter int          CAW      = 15,
    parameter int          DW       = 8,
    parameter logic [14:0] ADDR_A   = 15'h5555,
    parameter logic [14:0] ADDR_B   = 15'h2AAA,
    parameter logic [7:0]  D_LEAD   = 8'hAA,
    parameter logic [7:0]  D_SECOND = 8'h55,
    parameter logic [7:0]  D_ARM    = 8'hA0,
    parameter logic [7:0]  D_EXT    = 8'h80,
    parameter logic [7:0]  D_UNPROT = 8'h20,
    parameter logic [7:0]  D_IDIN   = 8'h90,
    parameter logic [7:0]  D_IDOUT  = 8'hF0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_stb,
    input  logic [CAW-1:0] wr_addr,
    input  logic [DW-1:0]  wr_data,
    output logic           byte_load,
    output cmd_hits_t      hits
);

    localparam logic [CAW-1:0] A_MATCH = ADDR_A[CAW-1:0];
    localparam logic [CAW-1:0] B_MATCH = ADDR_B[CAW-1:0];

    seq_t seq_q, seq_d;
    logic consumed;
    logic at_a, at_b;

    // Decode which command address the current write targets
    always_comb begin
        at_a = (wr_addr == A_MATCH);
        at_b = (wr_addr == B_MATCH);
    end

    // Next sequence step, command pulses and consume decision
    always_comb begin
        seq_d    = seq_q;
        consumed = 1'b0;
        hits     = '0;
        if (wr_stb) begin
            seq_d = SQ_IDLE;
            case (seq_q)
                SQ_IDLE: if (at_a && wr_data == D_LEAD) begin
                    seq_d = SQ_P1; consumed = 1'b1;
                end
                SQ_P1: if (at_b && wr_data == D_SECOND) begin
                    seq_d = SQ_P2; consumed = 1'b1;
                end
                SQ_P2: if (at_a) begin
                    if (wr_data == D_ARM) begin
                        hits.arm = 1'b1; consumed = 1'b1;
                    end else if (wr_data == D_IDIN) begin
                        hits.id_in = 1'b1; consumed = 1'b1;
                    end else if (wr_data == D_IDOUT) begin
                        hits.id_out = 1'b1; consumed = 1'b1;
                    end else if (wr_data == D_EXT) begin
                        seq_d = SQ_D3; consumed = 1'b1;
                    end
                end
                SQ_D3: if (at_a && wr_data == D_LEAD) begin
                    seq_d = SQ_D4; consumed = 1'b1;
                end
                SQ_D4: if (at_b && wr_data == D_SECOND) begin
                    seq_d = SQ_D5; consumed = 1'b1;
                end
                SQ_D5: if (at_a && wr_data == D_UNPROT) begin
                    hits.unprot = 1'b1; consumed = 1'b1;
                end
                default: seq_d = SQ_IDLE;
            endcase
        end
    end

    // Ordinary data byte: a write the matcher did not take
    always_comb byte_load = wr_stb && !consumed;

    // Sequence progress register
    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= SQ_IDLE;
        else        seq_q <= seq_d;
    end

endmodule

// File: rtl/wp_prot_reg.sv
// Module: persistent protection flag with pending changes.
// Holds the protection flag, which only the factory clear resets. Holds
// the per-cycle unlock and the pending enable/disable, which the normal
// reset clears. Flag changes are applied at the end of a program cycle.
// Assumes cyc_end is a one-cycle pulse from the program controller.
module wp_prot_reg
    import wp_cmd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      factory_n,
    input  cmd_hits_t hits,
    input  logic      cyc_end,
    output logic      prot_on,
    output logic      write_ok
);

    logic armed_q, pend_en_q, pend_dis_q;

    // Unlock and pending flag changes for the current program cycle
    always_ff @(posedge clk) begin
        if (!rst_n || cyc_end) begin
            armed_q    <= 1'b0;
            pend_en_q  <= 1'b0;
            pend_dis_q <= 1'b0;
        end else if (hits.arm) begin
            armed_q    <= 1'b1;
            pend_en_q  <= !prot_on;
            pend_dis_q <= 1'b0;
        end else if (hits.unprot) begin
            armed_q    <= 1'b1;
            pend_en_q  <= 1'b0;
            pend_dis_q <= 1'b1;
        end
    end

    // Persistent protection flag, untouched by the normal reset
    always_ff @(posedge clk) begin
        if (!factory_n)             prot_on <= 1'b0;
        else if (cyc_end) begin
            if (pend_en_q)          prot_on <= 1'b1;
            else if (pend_dis_q)    prot_on <= 1'b0;
        end
    end

    // Array update allowed when unprotected or unlocked for this cycle
    always_comb write_ok = !prot_on || armed_q;

endmodule

// File: rtl/wp_id_mux.sv
// Module: identification mode flag and read redirection.
// Enters and leaves identification mode on the matcher's pulses. While
// in the mode, replaces array read data with fixed codes chosen by the
// lowest read address bit. The normal reset leaves the mode.
module wp_id_mux
    import wp_cmd_pkg::*;
#(
    parameter int          DW  = 8,
    parameter logic [7:0]  MFR = 8'h1F,
    parameter logic [7:0]  DEV = 8'hDA
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cmd_hits_t     hits,
    input  logic          rd_a0,
    input  logic [DW-1:0] arr_data,
    output logic          id_mode,
    output logic [DW-1:0] rd_data
);

    // Identification mode flag
    always_ff @(posedge clk) begin
        if (!rst_n)            id_mode <= 1'b0;
        else if (hits.id_in)   id_mode <= 1'b1;
        else if (hits.id_out)  id_mode <= 1'b0;
    end

    // Read data selection
    always_comb begin
        if (id_mode) rd_data = rd_a0 ? DEV[DW-1:0] : MFR[DW-1:0];
        else         rd_data = arr_data;
    end

endmodule

// File: rtl/wp_cmd_seq.sv
// Module: write-protect command sequencer (top).
// Connects the sequence matcher, the protection register and the
// identification read mux. Assumes writes arrive as single-cycle strobes
// and cyc_end marks the end of each program cycle.
module wp_cmd_seq
    import wp_cmd_pkg::*;
#(
    parameter int          CAW       = 15,
    parameter int          DW        = 8,
    parameter logic [14:0] ADDR_A    = 15'h5555,
    parameter logic [14:0] ADDR_B    = 15'h2AAA,
    parameter logic [7:0]  MFR_CODE  = 8'h1F,
    parameter logic [7:0]  DEV_CODE  = 8'hDA
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           factory_n,
    input  logic           wr_stb,
    input  logic [CAW-1:0] wr_addr,
    input  logic [DW-1:0]  wr_data,
    input  logic           cyc_end,
    input  logic           rd_a0,
    input  logic [DW-1:0]  arr_data,
    output logic           byte_load,
    output logic           write_ok,
    output logic           prot_on,
    output logic           id_mode,
    output logic [DW-1:0]  rd_data
);

    cmd_hits_t hits;

    wp_cmd_match #(
        .CAW(CAW), .DW(DW), .ADDR_A(ADDR_A), .ADDR_B(ADDR_B)
    ) u_match (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .byte_load(byte_load), .hits(hits)
    );

    wp_prot_reg u_prot (
        .clk(clk), .rst_n(rst_n), .factory_n(factory_n), .hits(hits),
        .cyc_end(cyc_end), .prot_on(prot_on), .write_ok(write_ok)
    );

    wp_id_mux #(
        .DW(DW), .MFR(MFR_CODE), .DEV(DEV_CODE)
    ) u_id (
        .clk(clk), .rst_n(rst_n), .hits(hits), .rd_a0(rd_a0),
        .arr_data(arr_data), .id_mode(id_mode), .rd_data(rd_data)
    );

endmodule

// File: rtl/wp_cmd_seq_chk.sv
// Module: assertion checker for the write-protect command sequencer.
// Attached to the top module by the bind statement at the end of the file.
module wp_cmd_seq_chk
    import wp_cmd_pkg::*;
#(
    parameter int         DW  = 8,
    parameter logic [7:0] MFR = 8'h1F,
    parameter logic [7:0] DEV = 8'hDA
) (
    input logic          clk,
    input logic          rst_n,
    input logic          factory_n,
    input logic          wr_stb,
    input logic          cyc_end,
    input logic          byte_load,
    input logic          write_ok,
    input logic          prot_on,
    input logic          id_mode,
    input logic [DW-1:0] rd_data,
    input cmd_hits_t     hits
);

    // R5
    prot_hold_chk: assert property (@(posedge clk) disable iff (!factory_n)
        !cyc_end |=> $stable(prot_on));

    // R1
    load_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_load |-> (wr_stb && hits == '0));

    // R1
    hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({byte_load, hits}));

    // R7
    rst_clear_chk: assert property (@(posedge clk) disable iff (!factory_n)
        !rst_n |=> (!id_mode && write_ok == !prot_on));

    // R3
    end_disarm_chk: assert property (@(posedge clk)
        disable iff (!rst_n || !factory_n)
        cyc_end |=> (write_ok == !prot_on));

    // R2
    prot_rise_chk: assert property (@(posedge clk) disable iff (!factory_n)
        $rose(prot_on) |-> $past(cyc_end));

    // R6
    id_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        id_mode |-> (rd_data == MFR[DW-1:0] || rd_data == DEV[DW-1:0]));

endmodule

bind wp_cmd_seq wp_cmd_seq_chk #(.DW(DW), .MFR(MFR_CODE), .DEV(DEV_CODE)) u_chk (
    .clk(clk), .rst_n(rst_n), .factory_n(factory_n), .wr_stb(wr_stb),
    .cyc_end(cyc_end), .byte_load(byte_load), .write_ok(write_ok),
    .prot_on(prot_on), .id_mode(id_mode), .rd_data(rd_data), .hits(hits)
);

// File: tb/wp_cmd_seq_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks push expected values into a queue.
// The monitor pops them 3 ns after each falling edge and compares them.
module wp_cmd_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        factory_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic [14:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        cyc_end = 1'b0;
    logic        rd_a0 = 1'b0;
    logic [7:0]  arr_data = 8'h5C;
    logic        byte_load, write_ok, prot_on, id_mode;
    logic [7:0]  rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int         kind;   // 0 byte_load 1 write_ok 2 prot_on 3 id_mode 4 rd_data
        logic [7:0] val;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    wp_cmd_seq u_wp_cmd_seq (
        .clk(clk), .rst_n(rst_n), .factory_n(factory_n), .wr_stb(wr_stb),
        .wr_addr(wr_addr), .wr_data(wr_data), .cyc_end(cyc_end),
        .rd_a0(rd_a0), .arr_data(arr_data), .byte_load(byte_load),
        .write_ok(write_ok), .prot_on(prot_on), .id_mode(id_mode),
        .rd_data(rd_data)
    );

    // Monitor: compare queued expectations against the ports
    initial begin
        forever begin
            @(negedge clk);
            #3;
            while (sb.size() > 0) begin
                exp_t e;
                logic [7:0] obs;
                e = sb.pop_front();
                case (e.kind)
                    0: obs = {7'd0, byte_load};
                    1: obs = {7'd0, write_ok};
                    2: obs = {7'd0, prot_on};
                    3: obs = {7'd0, id_mode};
                    default: obs = rd_data;
                endcase
                checks++;
                if (obs !== e.val) begin
                    errors++;
                    $display("FAIL %s kind %0d: actual %h expected %h", e.tag, e.kind, obs, e.val);
                end
            end
        end
    end

    task automatic drive(input logic stb, input logic [14:0] a, input logic [7:0] d,
                         input logic ce, input logic rn, input logic fn);
        @(negedge clk);
        wr_stb = stb; wr_addr = a; wr_data = d; cyc_end = ce;
        rst_n = rn; factory_n = fn;
    endtask

    task automatic expect_v(input int kind, input logic [7:0] v, input string tag);
        exp_t e;
        e.kind = kind; e.val = v; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic wr(input logic [14:0] a, input logic [7:0] d, input logic ld, input string tag);
        drive(1'b1, a, d, 1'b0, 1'b1, 1'b1);
        expect_v(0, {7'd0, ld}, tag);
    endtask

    task automatic idle();
        drive(1'b0, '0, '0, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic end_cycle();
        drive(1'b0, '0, '0, 1'b1, 1'b1, 1'b1);
    endtask

    task automatic prefix(input string tag);
        wr(15'h5555, 8'hAA, 1'b0, tag);
        wr(15'h2AAA, 8'h55, 1'b0, tag);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Watchdog
    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    // Driver
    initial begin
        repeat (3) drive(1'b0, '0, '0, 1'b0, 1'b0, 1'b0);
        idle();
        expect_v(2, 8'd0, "R5 reset prot");
        expect_v(3, 8'd0, "R7 reset id");
        expect_v(1, 8'd1, "R3 reset write_ok");

        // R1 ordinary writes, R2 enable with unlock
        wr(15'h0100, 8'h12, 1'b1, "R1 data write");
        prefix("R1 prefix");
        wr(15'h5555, 8'hA0, 1'b0, "R2 arm byte");
        idle();
        expect_v(2, 8'd0, "R2 not before end");
        expect_v(1, 8'd1, "R2 write_ok");
        wr(15'h0003, 8'h44, 1'b1, "R1 sector byte");
        end_cycle();
        idle();
        expect_v(2, 8'd1, "R2 prot after end");
        expect_v(1, 8'd0, "R3 locked after end");

        // R3 unarmed then armed write
        wr(15'h0200, 8'h33, 1'b1, "R3 unarmed load");
        idle();
        expect_v(1, 8'd0, "R3 unarmed");
        prefix("R3 prefix");
        wr(15'h5555, 8'hA0, 1'b0, "R3 arm");
        idle();
        expect_v(1, 8'd1, "R3 armed");
        end_cycle();
        idle();
        expect_v(1, 8'd0, "R3 disarmed");
        expect_v(2, 8'd1, "R2 stays on");

        // R5 and R7 reset behaviour
        prefix("R7 prefix");
        drive(1'b0, '0, '0, 1'b0, 1'b0, 1'b1);
        wr(15'h5555, 8'hA0, 1'b1, "R7 progress cleared");
        prefix("R7 prefix2");
        wr(15'h5555, 8'hA0, 1'b0, "R7 arm");
        drive(1'b0, '0, '0, 1'b0, 1'b0, 1'b1);
        idle();
        expect_v(1, 8'd0, "R7 unlock cleared");
        expect_v(2, 8'd1, "R5 survives reset");

        // R8 abort
        prefix("R8 prefix");
        wr(15'h5555, 8'h77, 1'b1, "R8 abort byte");
        idle();
        expect_v(1, 8'd0, "R8 no arm");
        wr(15'h5555, 8'hAA, 1'b0, "R8 restart");
        wr(15'h2AAA, 8'h12, 1'b1, "R8 abort at second");

        // R4 disable
        prefix("R4 prefix");
        wr(15'h5555, 8'h80, 1'b0, "R4 ext");
        wr(15'h5555, 8'hAA, 1'b0, "R4 lead2");
        wr(15'h2AAA, 8'h55, 1'b0, "R4 second2");
        wr(15'h5555, 8'h20, 1'b0, "R4 final");
        idle();
        expect_v(1, 8'd1, "R4 write_ok");
        expect_v(2, 8'd1, "R4 prot until end");
        end_cycle();
        idle();
        expect_v(2, 8'd0, "R4 prot cleared");
        expect_v(1, 8'd1, "R4 unprotected write_ok");

        // R9 and R6 identification
        rd_a0 = 1'b0;
        expect_v(4, 8'h5C, "R9 array read");
        prefix("R6 prefix");
        wr(15'h5555, 8'h90, 1'b0, "R6 entry");
        idle();
        expect_v(3, 8'd1, "R6 id on");
        expect_v(4, 8'h1F, "R6 mfr code");
        idle();
        rd_a0 = 1'b1;
        expect_v(4, 8'hDA, "R6 dev code");
        prefix("R6 prefix exit");
        wr(15'h5555, 8'hF0, 1'b0, "R6 exit");
        idle();
        expect_v(3, 8'd0, "R6 id off");
        expect_v(4, 8'h5C, "R9 array restored");
        prefix("R7 id prefix");
        wr(15'h5555, 8'h90, 1'b0, "R7 id entry");
        drive(1'b0, '0, '0, 1'b0, 1'b0, 1'b1);
        idle();
        expect_v(3, 8'd0, "R7 id cleared");

        // R5 factory clear
        prefix("R5 prefix");
        wr(15'h5555, 8'hA0, 1'b0, "R5 arm");
        end_cycle();
        idle();
        expect_v(2, 8'd1, "R5 prot set");
        drive(1'b0, '0, '0, 1'b0, 1'b1, 1'b0);
        idle();
        expect_v(2, 8'd0, "R5 factory clear");

        repeat (3) idle();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule